// File: doc/BRIEF.md
# Staged Byte Store With Echo-Authorized Commit

This block carries out four memory commands that arrive as whole bytes from a serial front end that has already assembled them. Writes never go straight into the 544-byte store. They first land in a 32-byte staging page. The store is updated only when the host repeats the target address and the status byte exactly. This lets the host read the staging page back and check it before anything permanent changes. The status byte records three things: where writing stopped, whether writing ran past the end of the page, and whether the final byte was incomplete. Because that byte is part of the required echo, a host that ignores these flags cannot commit data.

Incoming bytes use a valid/ready stream. A byte is accepted on any clock where `rx_valid` and `rx_ready` are both high. `rx_ready` drops only while a commit is being written, one byte per clock. Outgoing bytes use a second valid/ready stream. The block raises `tx_valid` only in phases where it has data to return. It holds `tx_data` stable until the consumer takes the byte with `tx_ready`. Bytes the consumer has not asked for are never lost. `bus_rst` is a plain one-cycle strobe that ends the current transaction.

Top module: `sp_copy_ctrl`

## Requirements
- R1: Command 0Fh takes a low address byte and then a high address byte to form the 16-bit target. The end offset is first set to target[4:0]. Each following data byte is stored at the current page offset, starting at target[4:0]. The end offset then takes that offset, and the offset advances by one.
- R2: Accepting command 0Fh clears the partial, overflow and authorized flags. The authorized flag is cleared by nothing else, so it survives bus resets, reads and further commits.
- R3: A data byte that arrives after offset 31 has been written sets the overflow flag. That byte and every later one are discarded, and the staging page and end offset are left unchanged.
- R4: A data byte accepted with `rx_partial` high is stored whole and sets the partial flag. If it arrives after overflow, it is discarded and the partial flag is not set.
- R5: The status byte is {authorized, overflow, partial, end[4:0]}, with authorized in bit 7. Command AAh returns the target low byte, the target high byte and the status byte. It then returns page bytes from offset target[4:0] through 31, and FFh for every byte after that.
- R6: Command 55h takes three bytes, which must equal the target low byte, the target high byte and the current status byte, in that order. On a match, the authorized flag is set. Page offsets target[4:0] through end are then written to consecutive store addresses starting at the target, wrapping within the page, one byte per clock. During this time `busy` is high and `rx_ready` is low.
- R7: After a commit finishes, the block returns 00h bytes until a bus reset. After a mismatch it returns FFh bytes and the store is unchanged.
- R8: Command F0h takes a new target address, which it also loads into the target register. It then streams store bytes from that address through 21Dh, and FFh after that. The status byte is left unchanged.
- R9: `bus_rst` has no effect while a commit is being written. The commit runs to completion and is followed by 00h bytes.
- R10: `bus_rst` at any other time returns the block to waiting for a command. An unrecognized command byte produces FFh bytes until a bus reset.
- R11: After `rst_n`, the block waits for a command with `tx_valid` low, `rx_ready` high and `busy` low. While `tx_valid` is high and `tx_ready` is low, `tx_data` holds its value. Bytes received during output phases are accepted and ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rst | input | 1 | One-cycle strobe ending the current transaction |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Block can accept a received byte |
| rx_data | input | 8 | Received byte |
| rx_partial | input | 1 | Qualifies the received byte as incomplete |
| tx_valid | output | 1 | Block offers a byte to send |
| tx_ready | input | 1 | Consumer takes the offered byte |
| tx_data | output | 8 | Byte to send |
| busy | output | 1 | Commit in progress |

## Verification
The hardest situation to reach from the ports is a bus reset that arrives while a commit is being written. That window lasts only as many clocks as there are bytes being committed. The stimulus stages four bytes, sends a matching echo, and raises `bus_rst` on the very next cycle, while `busy` is high. It then checks that 00h bytes follow and that all four bytes are present in the store. A second difficult case is a commit whose echo already includes the authorized bit. This requires a first successful commit, a read-back of the new status byte, and then a second echo that uses that byte.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [3:0] {
    S_CMD, S_WS_TA1, S_WS_TA2, S_WS_DATA, S_RS_OUT,
    S_CP_A1, S_CP_A2, S_CP_ES, S_COPY, S_CP_DONE, S_FILL,
    S_RM_TA1, S_RM_TA2, S_RM_OUT
  } state_t;

  localparam logic [7:0] CMD_WR_SP  = 8'h0F;
  localparam logic [7:0] CMD_RD_SP  = 8'hAA;
  localparam logic [7:0] CMD_COPY   = 8'h55;
  localparam logic [7:0] CMD_RD_MEM = 8'hF0;
endpackage

// File: rtl/sp_byte_ram.sv
module sp_byte_ram #(
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we && ({1'b0, waddr} < LIMIT)) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = ({1'b0, raddr} < LIMIT) ? cells[raddr] : 8'hFF;
endmodule

// File: rtl/sp_tx_sel.sv
module sp_tx_sel import sp_pkg::*; #(
  parameter int AW        = 16,
  parameter int LAST_ADDR = 541
) (
  input  state_t        state,
  input  logic [1:0]    rs_hdr,
  input  logic          rs_end,
  input  logic [AW-1:0] ta,
  input  logic [7:0]    es,
  input  logic [7:0]    sp_rd,
  input  logic [AW-1:0] rm_addr,
  input  logic [7:0]    mem_rd,
  output logic [7:0]    tx_data
);
  always_comb begin
    tx_data = 8'hFF;
    case (state)
      S_RS_OUT: begin
        case (rs_hdr)
          2'd0:    tx_data = ta[7:0];
          2'd1:    tx_data = ta[15:8];
          2'd2:    tx_data = es;
          default: tx_data = rs_end ? 8'hFF : sp_rd;
        endcase
      end
      S_CP_DONE: tx_data = 8'h00;
      S_RM_OUT:  tx_data = (rm_addr > AW'(LAST_ADDR)) ? 8'hFF : mem_rd;
      default:   tx_data = 8'hFF;
    endcase
  end
endmodule

// File: rtl/sp_copy_ctrl.sv
module sp_copy_ctrl import sp_pkg::*; #(
  parameter int SP_BYTES  = 32,
  parameter int MEM_BYTES = 544,
  parameter int LAST_ADDR = 541,
  parameter int AW        = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_rst,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic [7:0] rx_data,
  input  logic       rx_partial,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic [7:0] tx_data,
  output logic       busy
);
  localparam int OFF_W = $clog2(SP_BYTES);
  localparam logic [OFF_W:0]   WOFF_ONE = (OFF_W+1)'(1);
  localparam logic [OFF_W-1:0] OFF_ONE  = OFF_W'(1);
  localparam logic [AW-1:0]    ADDR_ONE = AW'(1);

  state_t             state_q;
  logic [AW-1:0]      ta_q, cp_addr_q, rm_addr_q;
  logic [OFF_W-1:0]   e_q, cp_off_q;
  logic [OFF_W:0]     wr_off_q, rs_off_q;
  logic [1:0]         rs_hdr_q;
  logic               pf_q, of_q, aa_q, auth_q;
  logic               rx_fire, tx_fire;
  logic [7:0]         es_byte, sp_rd, mem_rd;
  logic               sp_we;
  logic [OFF_W-1:0]   sp_raddr;

  assign busy     = (state_q == S_COPY);
  assign rx_ready = !busy;
  assign tx_valid = (state_q == S_RS_OUT) || (state_q == S_CP_DONE) ||
                    (state_q == S_FILL)   || (state_q == S_RM_OUT);
  assign rx_fire  = rx_valid && rx_ready;
  assign tx_fire  = tx_valid && tx_ready;
  assign es_byte  = {aa_q, of_q, pf_q, e_q};

  assign sp_we    = (state_q == S_WS_DATA) && rx_fire && !bus_rst && !wr_off_q[OFF_W];
  assign sp_raddr = busy ? cp_off_q : rs_off_q[OFF_W-1:0];

  sp_byte_ram #(.DEPTH(SP_BYTES), .AW(OFF_W)) u_page (
    .clk(clk), .rst_n(rst_n), .we(sp_we), .waddr(wr_off_q[OFF_W-1:0]),
    .wdata(rx_data), .raddr(sp_raddr), .rdata(sp_rd)
  );

  sp_byte_ram #(.DEPTH(MEM_BYTES), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(busy), .waddr(cp_addr_q),
    .wdata(sp_rd), .raddr(rm_addr_q), .rdata(mem_rd)
  );

  sp_tx_sel #(.AW(AW), .LAST_ADDR(LAST_ADDR)) u_txsel (
    .state(state_q), .rs_hdr(rs_hdr_q), .rs_end(rs_off_q[OFF_W]),
    .ta(ta_q), .es(es_byte), .sp_rd(sp_rd), .rm_addr(rm_addr_q),
    .mem_rd(mem_rd), .tx_data(tx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_CMD;
      ta_q      <= '0;
      e_q       <= '0;
      pf_q      <= 1'b0;
      of_q      <= 1'b0;
      aa_q      <= 1'b0;
      auth_q    <= 1'b0;
      wr_off_q  <= '0;
      rs_off_q  <= '0;
      rs_hdr_q  <= '0;
      cp_off_q  <= '0;
      cp_addr_q <= '0;
      rm_addr_q <= '0;
    end else if (bus_rst && !busy) begin
      state_q <= S_CMD;
    end else begin
      case (state_q)
        S_CMD: if (rx_fire) begin
          case (rx_data)
            CMD_WR_SP: begin
              pf_q <= 1'b0; of_q <= 1'b0; aa_q <= 1'b0;
              state_q <= S_WS_TA1;
            end
            CMD_RD_SP: begin
              rs_hdr_q <= '0;
              rs_off_q <= {1'b0, ta_q[OFF_W-1:0]};
              state_q  <= S_RS_OUT;
            end
            CMD_COPY: begin
              auth_q  <= 1'b1;
              state_q <= S_CP_A1;
            end
            CMD_RD_MEM: state_q <= S_RM_TA1;
            default:    state_q <= S_FILL;
          endcase
        end
        S_WS_TA1: if (rx_fire) begin
          ta_q[7:0] <= rx_data;
          state_q   <= S_WS_TA2;
        end
        S_WS_TA2: if (rx_fire) begin
          ta_q[15:8] <= rx_data;
          e_q        <= ta_q[OFF_W-1:0];
          wr_off_q   <= {1'b0, ta_q[OFF_W-1:0]};
          state_q    <= S_WS_DATA;
        end
        S_WS_DATA: if (rx_fire) begin
          if (wr_off_q[OFF_W]) begin
            of_q <= 1'b1;
          end else begin
            e_q      <= wr_off_q[OFF_W-1:0];
            wr_off_q <= wr_off_q + WOFF_ONE;
            if (rx_partial) pf_q <= 1'b1;
          end
        end
        S_RS_OUT: if (tx_fire) begin
          if (rs_hdr_q != 2'd3)        rs_hdr_q <= rs_hdr_q + 2'd1;
          else if (!rs_off_q[OFF_W])   rs_off_q <= rs_off_q + WOFF_ONE;
        end
        S_CP_A1: if (rx_fire) begin
          auth_q  <= auth_q && (rx_data == ta_q[7:0]);
          state_q <= S_CP_A2;
        end
        S_CP_A2: if (rx_fire) begin
          auth_q  <= auth_q && (rx_data == ta_q[15:8]);
          state_q <= S_CP_ES;
        end
        S_CP_ES: if (rx_fire) begin
          if (auth_q && (rx_data == es_byte)) begin
            aa_q      <= 1'b1;
            cp_off_q  <= ta_q[OFF_W-1:0];
            cp_addr_q <= ta_q;
            state_q   <= S_COPY;
          end else begin
            state_q <= S_FILL;
          end
        end
        S_COPY: begin
          if (cp_off_q == e_q) begin
            state_q <= S_CP_DONE;
          end else begin
            cp_off_q  <= cp_off_q + OFF_ONE;
            cp_addr_q <= cp_addr_q + ADDR_ONE;
          end
        end
        S_RM_TA1: if (rx_fire) begin
          ta_q[7:0] <= rx_data;
          state_q   <= S_RM_TA2;
        end
        S_RM_TA2: if (rx_fire) begin
          ta_q[15:8] <= rx_data;
          rm_addr_q  <= {rx_data, ta_q[7:0]};
          state_q    <= S_RM_OUT;
        end
        S_RM_OUT: if (tx_fire && (rm_addr_q <= AW'(LAST_ADDR))) begin
          rm_addr_q <= rm_addr_q + ADDR_ONE;
        end
        default: ;
      endcase
    end
  end

  // R2
  aa_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aa_q) |-> $past(state_q == S_CMD && rx_fire && rx_data == CMD_WR_SP));

  // R3
  of_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (of_q && !(state_q == S_CMD && rx_fire && rx_data == CMD_WR_SP)) |=> of_q);

  // R6
  commit_auth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> aa_q);

  // R9
  rst_during_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_rst) |=> (state_q == S_COPY || state_q == S_CP_DONE));

  // R11
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !bus_rst) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: tb/tb_sp_copy_ctrl.sv
module tb_sp_copy_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rst = 1'b0, rx_valid = 1'b0, rx_partial = 1'b0, tx_ready = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic rx_ready, tx_valid, busy;
  logic [7:0] tx_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  sp_copy_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_partial(rx_partial),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .busy(busy)
  );

  // Behavioural reference: modes are integers, commit is a queue of writes
  int md, ta, e, pf, ofl, aa, wpos, rsk, rma, auth;
  logic [7:0] sp [32];
  logic [7:0] mm [544];
  int qa[$];
  int qd[$];

  function automatic int m_esb();
    return (aa << 7) | (ofl << 6) | (pf << 5) | e;
  endfunction

  function automatic logic m_txv();
    return (md == 4) || (md == 9) || (md == 10) || (md == 13);
  endfunction

  function automatic logic [7:0] m_txd();
    int off;
    case (md)
      4: begin
        if (rsk == 0) return 8'(ta & 255);
        if (rsk == 1) return 8'(ta >> 8);
        if (rsk == 2) return 8'(m_esb());
        off = (ta & 31) + rsk - 3;
        return (off < 32) ? sp[off] : 8'hFF;
      end
      9:  return 8'h00;
      13: return (rma <= 'h21D) ? mm[rma] : 8'hFF;
      default: return 8'hFF;
    endcase
  endfunction

  always @(posedge clk) begin
    int rx, off, adr;
    logic txf, rxf;
    if (!rst_n) begin
      md = 0; ta = 0; e = 0; pf = 0; ofl = 0; aa = 0; wpos = 0; rsk = 0; rma = 0; auth = 0;
      for (int i = 0; i < 32; i++) sp[i] = 8'h00;
      for (int i = 0; i < 544; i++) mm[i] = 8'h00;
      qa.delete(); qd.delete();
    end else begin
      txf = m_txv() && tx_ready;
      rxf = rx_valid && (md != 8);
      rx  = int'(rx_data);
      if (bus_rst && md != 8) md = 0;
      else begin
        case (md)
          0: if (rxf) begin
            if (rx == 'h0F) begin pf = 0; ofl = 0; aa = 0; md = 1; end
            else if (rx == 'hAA) begin rsk = 0; md = 4; end
            else if (rx == 'h55) begin auth = 1; md = 5; end
            else if (rx == 'hF0) md = 11;
            else md = 10;
          end
          1: if (rxf) begin ta = (ta & 'hFF00) | rx; md = 2; end
          2: if (rxf) begin ta = (rx << 8) | (ta & 255); e = ta & 31; wpos = ta & 31; md = 3; end
          3: if (rxf) begin
            if (wpos > 31) ofl = 1;
            else begin sp[wpos] = rx_data; e = wpos; wpos++; if (rx_partial) pf = 1; end
          end
          4: if (txf) rsk++;
          5: if (rxf) begin if (rx != (ta & 255)) auth = 0; md = 6; end
          6: if (rxf) begin if (rx != (ta >> 8)) auth = 0; md = 7; end
          7: if (rxf) begin
            if (auth == 1 && rx == m_esb()) begin
              aa = 1;
              off = ta & 31; adr = ta;
              forever begin
                qa.push_back(adr); qd.push_back(int'(sp[off]));
                if (off == e) break;
                off = (off + 1) % 32; adr = (adr + 1) & 'hFFFF;
              end
              md = 8;
            end else md = 10;
          end
          8: begin
            adr = qa.pop_front(); off = qd.pop_front();
            if (adr < 544) mm[adr] = 8'(off);
            if (qa.size() == 0) md = 9;
          end
          11: if (rxf) begin ta = (ta & 'hFF00) | rx; md = 12; end
          12: if (rxf) begin ta = (rx << 8) | (ta & 255); rma = ta; md = 13; end
          13: if (txf && rma <= 'h21D) rma++;
          default: ;
        endcase
      end
    end
  end

  // Per-cycle comparison against the reference (all requirements)
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (tx_valid !== m_txv() || busy !== (md == 8) || rx_ready !== (md != 8) ||
          (m_txv() && tx_data !== m_txd())) begin
        errors++;
        $display("FAIL model-compare R11: txv=%0b txd=%02h busy=%0b rdy=%0b expected txv=%0b txd=%02h busy=%0b rdy=%0b",
                 tx_valid, tx_data, busy, rx_ready, m_txv(), m_txd(), md == 8, md != 8);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual %0d cycles, expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic part = 1'b0);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b; rx_partial = part;
    @(negedge clk);
    rx_valid = 1'b0; rx_partial = 1'b0;
  endtask

  task automatic get(output logic [7:0] b);
    @(negedge clk);
    while (!tx_valid) @(negedge clk);
    tx_ready = 1'b1; b = tx_data;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic expect_tx(input string tag, input logic [7:0] exp);
    logic [7:0] b;
    get(b);
    chk(tag, b, exp);
  endtask

  task automatic brst();
    @(negedge clk); bus_rst = 1'b1;
    @(negedge clk); bus_rst = 1'b0;
  endtask

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 reset tx_valid", {7'd0, tx_valid}, 8'd0);
    chk("R11 reset rx_ready", {7'd0, rx_ready}, 8'd1);
    chk("R11 reset busy", {7'd0, busy}, 8'd0);

    // R1: stage two bytes at 0026h
    send(8'h0F); send(8'h26); send(8'h00); send(8'hAB); send(8'hCD);
    brst();
    send(8'hAA);
    expect_tx("R5 ta low", 8'h26);
    expect_tx("R5 ta high", 8'h00);
    expect_tx("R5 status end=7", 8'h07);
    expect_tx("R1 data first", 8'hAB);
    // R11 stall: hold tx_ready low for several cycles, then take
    repeat (4) @(negedge clk);
    chk("R11 held byte", tx_data, 8'hCD);
    expect_tx("R1 data second", 8'hCD);
    for (int i = 0; i < 24; i++) get(b);
    expect_tx("R5 past end FF", 8'hFF);
    brst();

    // R6 / R7: matching echo commits offsets 6..7
    send(8'h55); send(8'h26); send(8'h00); send(8'h07);
    chk("R6 busy during commit", {7'd0, busy}, 8'd1);
    chk("R6 rx_ready low during commit", {7'd0, rx_ready}, 8'd0);
    expect_tx("R7 zeros after commit", 8'h00);
    expect_tx("R7 zeros continue", 8'h00);
    brst();

    // R8: read store from 0024h
    send(8'hF0); send(8'h24); send(8'h00);
    expect_tx("R8 mem 24", 8'h00);
    expect_tx("R8 mem 25", 8'h00);
    expect_tx("R8 mem 26", 8'hAB);
    expect_tx("R8 mem 27", 8'hCD);
    brst();
    send(8'hAA);
    expect_tx("R8 ta low loaded", 8'h24);
    expect_tx("R8 ta high loaded", 8'h00);
    expect_tx("R2 R8 status kept, auth set", 8'h87);
    brst();
    send(8'hF0); send(8'h1C); send(8'h02);
    expect_tx("R8 mem 21C", 8'h00);
    expect_tx("R8 mem 21D", 8'h00);
    expect_tx("R8 FF after last", 8'hFF);
    expect_tx("R8 FF stays", 8'hFF);
    brst();

    // R3 / R4: overflow at 011Eh, partial byte after overflow ignored
    send(8'h0F); send(8'h1E); send(8'h01);
    send(8'h11); send(8'h22); send(8'h33, 1'b1);
    brst();
    send(8'hAA);
    expect_tx("R3 ta low", 8'h1E);
    expect_tx("R3 ta high", 8'h01);
    expect_tx("R3 R2 status overflow", 8'h5F);
    expect_tx("R3 data 30", 8'h11);
    expect_tx("R3 data 31", 8'h22);
    expect_tx("R3 R5 then FF", 8'hFF);
    brst();

    // R4: partial last byte at 0040h
    send(8'h0F); send(8'h40); send(8'h00);
    send(8'h77); send(8'h66); send(8'h55); send(8'h88, 1'b1);
    brst();
    // R7: wrong echo
    send(8'h55); send(8'h40); send(8'h00); send(8'h22);
    expect_tx("R7 FF after mismatch", 8'hFF);
    brst();
    send(8'hF0); send(8'h40); send(8'h00);
    expect_tx("R7 store untouched", 8'h00);
    brst();
    send(8'hAA);
    get(b); get(b);
    expect_tx("R4 status partial end=3", 8'h23);
    brst();

    // R9: bus reset on the first commit cycle
    send(8'h55); send(8'h40); send(8'h00); send(8'h23);
    bus_rst = 1'b1;
    @(negedge clk);
    bus_rst = 1'b0;
    chk("R9 still busy after reset strobe", {7'd0, busy}, 8'd1);
    expect_tx("R9 zeros after ignored reset", 8'h00);
    brst();
    send(8'hAA);
    get(b); get(b);
    expect_tx("R6 auth flag set", 8'hA3);
    brst();
    // R6: second commit with the authorized bit in the echo
    send(8'h55); send(8'h40); send(8'h00); send(8'hA3);
    expect_tx("R6 second commit accepted", 8'h00);
    brst();
    send(8'hF0); send(8'h40); send(8'h00);
    expect_tx("R6 mem 40", 8'h77);
    expect_tx("R6 mem 41", 8'h66);
    expect_tx("R6 mem 42", 8'h55);
    expect_tx("R4 partial copied whole", 8'h88);
    brst();

    // R1: no data bytes -> end offset equals target offset
    send(8'h0F); send(8'h05); send(8'h00);
    brst();
    send(8'hAA);
    expect_tx("R1 ta low", 8'h05);
    // R10: bus reset mid-stream restarts from command
    brst();
    send(8'hAA);
    expect_tx("R10 restart ta low", 8'h05);
    expect_tx("R10 restart ta high", 8'h00);
    expect_tx("R1 R2 status empty write", 8'h05);
    brst();
    // R10: unknown command
    send(8'h3C);
    expect_tx("R10 unknown command FF", 8'hFF);
    // R11: bytes received during output phase are ignored
    send(8'hAA);
    expect_tx("R11 rx ignored while sending", 8'hFF);
    brst();
    send(8'hAA);
    expect_tx("R10 command after reset", 8'h05);
    brst();

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule